// File: doc/BRIEF.md
# Cache-Selection System Register with Access Checking

This block owns one 64-bit system register that chooses which cache a later size query describes: a cache level, an instruction-versus-data choice and an allocation-tag cache choice. Every system-register request on the core's request port is offered to the block. The block answers only requests whose five-field encoding names this register. For each such request it decides whether the access is undefined, traps to the hypervisor level with a syndrome class, or completes.

The decision depends on the current exception level (0 to 3). At level 1 it also depends on an ordered chain of hypervisor trap controls. First comes a group-2 identification trap. Second is a group-4 identification trap, which counts only when the extended-trap feature is present. Third is a fine-grained trap, which has separate read and write bits. A completed write stores the value after masking out illegal field values. A completed read returns the stored value through a view that hides fields that are not present.

A two-state machine sequences each answer. `S_IDLE` waits for a matching request. The transition `IDLE->ANSWER` is taken when a matching request arrives. In `S_ANSWER` the response strobe is high for one cycle, with the outcome and the read data. From there, `ANSWER->ANSWER` is taken on a back-to-back matching request and `ANSWER->IDLE` otherwise. `IDLE->IDLE` holds while nothing matches.

Top module: `sysreg_cachesel`

## Requirements
- R1: A request whose encoding is not op0=3, op1=2, CRn=0, CRm=0, op2=0 gets no response (rsp_valid stays 0 the next cycle), and a write carried by such a request does not change the stored value.
- R2: A matching request raises rsp_valid for exactly one cycle, in the cycle after the request; rsp_code is 0 for completed, 1 for undefined and 2 for trap.
- R3: A matching request at level 0 (cur_el=0) returns undefined.
- R4: At level 2 or 3, reads and writes complete with no trap check.
- R5: At level 1 with el2_enabled=0, accesses complete whatever the trap controls are.
- R6: At level 1 with el2_enabled=1, trap_idgrp2=1 traps with rsp_class 0x18; this check has the highest priority.
- R7: The second check traps on trap_idgrp4=1 only when has_ext_idtrap=1.
- R8: The third check traps when has_fine_trap=1, and either has_el3=0 or el3_fine_en=1, and the fine-grained bit for the access direction is set: fine_rd_trap for reads and fine_wr_trap for writes.
- R9: In the stored layout, bit 0 selects the instruction cache and bits 3:1 hold the level. Bits 63:5 always read 0.
- R10: Bit 4 (tag cache) is stored only when has_tag_cache=1 and the written bit 0 is 0. Reads show bit 4 as 0 while has_tag_cache=0.
- R11: A write with level 0b111 leaves the stored level unchanged and still updates the other fields.
- R12: A read whose stored level is not below NUM_LEVELS returns level and bit 0 as 0.
- R13: After reset the stored value reads as zero.
- R14: A write that is undefined or trapped leaves the stored value unchanged; a read data of zero accompanies any non-completed or write response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current exception level |
| el2_enabled | input | 1 | Hypervisor level enabled |
| trap_idgrp2 | input | 1 | Group-2 identification trap |
| trap_idgrp4 | input | 1 | Group-4 identification trap |
| has_ext_idtrap | input | 1 | Extended identification-trap feature present |
| has_fine_trap | input | 1 | Fine-grained trap feature present |
| has_el3 | input | 1 | Level 3 implemented |
| el3_fine_en | input | 1 | Fine-grained trap enable from level 3 |
| fine_rd_trap | input | 1 | Fine-grained read trap bit for this register |
| fine_wr_trap | input | 1 | Fine-grained write trap bit for this register |
| has_tag_cache | input | 1 | Memory-tagging feature present |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | Outcome: 0 done, 1 undefined, 2 trap |
| rsp_class | output | 6 | Syndrome class (0x18 on trap, else 0) |
| rsp_rdata | output | 64 | Read data |

## Verification
The bench goes after the trap chain's priority and its feature gating. A design that checked the group-4 bit without the feature would trap accesses that must complete. A design that used the read fine-grained bit for writes would trap the wrong direction, and one that ignored the level-3 enable would trap when it should not. Storage masking is pushed through several cases: the reserved level, the tag bit written alongside the instruction bit, the tag bit written without the feature, and the upper bits. A design that got these wrong would read back an illegal level or a set tag bit. Reads of an unimplemented level, and writes that are undefined or trapped, show whether the read view masks fields and whether rejected writes leak into storage.

// File: rtl/cachesel_pkg.sv
package cachesel_pkg;
    localparam int DATA_W  = 64;
    localparam int CLASS_W = 6;

    localparam logic [1:0] ENC_OP0 = 2'b11;
    localparam logic [2:0] ENC_OP1 = 3'b010;
    localparam logic [3:0] ENC_CRN = 4'b0000;
    localparam logic [3:0] ENC_CRM = 4'b0000;
    localparam logic [2:0] ENC_OP2 = 3'b000;

    localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

    typedef enum logic [1:0] {
        OUT_DONE  = 2'b00,
        OUT_UNDEF = 2'b01,
        OUT_TRAP  = 2'b10
    } outcome_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_ANSWER = 1'b1
    } rsp_state_e;

    typedef struct packed {
        logic       tag;
        logic [2:0] lvl;
        logic       ind;
    } sel_fields_t;
endpackage

// File: rtl/csel_decode.sv
module csel_decode
    import cachesel_pkg::*;
(
    input  logic       req_valid,
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    always_comb begin
        hit = req_valid && (op0 == ENC_OP0) && (op1 == ENC_OP1) &&
              (crn == ENC_CRN) && (crm == ENC_CRM) && (op2 == ENC_OP2);
    end
endmodule

// File: rtl/csel_gate.sv
module csel_gate
    import cachesel_pkg::*;
(
    input  logic     is_write,
    input  logic [1:0] el,
    input  logic     el2_enabled,
    input  logic     trap_idgrp2,
    input  logic     trap_idgrp4,
    input  logic     has_ext_idtrap,
    input  logic     has_fine_trap,
    input  logic     has_el3,
    input  logic     el3_fine_en,
    input  logic     fine_rd_trap,
    input  logic     fine_wr_trap,
    output outcome_e outcome
);
    logic fine_active;
    logic fine_bit;

    always_comb begin
        fine_bit    = is_write ? fine_wr_trap : fine_rd_trap;
        fine_active = has_fine_trap && (!has_el3 || el3_fine_en) && fine_bit;
    end

    always_comb begin
        outcome = OUT_DONE;
        unique case (el)
            2'd0: outcome = OUT_UNDEF;
            2'd1: begin
                if (!el2_enabled)                        outcome = OUT_DONE;
                else if (trap_idgrp2)                    outcome = OUT_TRAP;
                else if (has_ext_idtrap && trap_idgrp4)  outcome = OUT_TRAP;
                else if (fine_active)                    outcome = OUT_TRAP;
                else                                     outcome = OUT_DONE;
            end
            2'd2:    outcome = OUT_DONE;
            2'd3:    outcome = OUT_DONE;
            default: outcome = OUT_UNDEF;
        endcase
    end
endmodule

// File: rtl/csel_store.sv
module csel_store
    import cachesel_pkg::*;
#(
    parameter int NUM_LEVELS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              has_tag_cache,
    output logic [DATA_W-1:0] rd_view
);
    localparam logic [3:0] LVL_LIMIT = 4'(NUM_LEVELS);
    localparam int         PAD_W     = DATA_W - 5;

    sel_fields_t cur_q;
    sel_fields_t nxt;
    logic        lvl_absent;

    always_comb begin
        nxt     = cur_q;
        nxt.ind = wdata[0];
        if (wdata[3:1] != 3'b111) nxt.lvl = wdata[3:1];
        nxt.tag = has_tag_cache && !wdata[0] && wdata[4];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cur_q <= '0;
        else if (wr_en) cur_q <= nxt;
    end

    always_comb begin
        lvl_absent = ({1'b0, cur_q.lvl} >= LVL_LIMIT);
        rd_view    = {{PAD_W{1'b0}},
                      cur_q.tag && has_tag_cache,
                      lvl_absent ? 3'b000 : cur_q.lvl,
                      cur_q.ind && !lvl_absent};
    end

    AST_LEVEL_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.lvl != 3'b111); // R11
    AST_TAG_EXCLUDES_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.ind |-> !cur_q.tag); // R10
    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cur_q)); // R14
endmodule

// File: rtl/sysreg_cachesel.sv
module sysreg_cachesel
    import cachesel_pkg::*;
#(
    parameter int NUM_LEVELS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_op0,
    input  logic [2:0]  req_op1,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op2,
    input  logic [63:0] req_wdata,
    input  logic [1:0]  cur_el,
    input  logic        el2_enabled,
    input  logic        trap_idgrp2,
    input  logic        trap_idgrp4,
    input  logic        has_ext_idtrap,
    input  logic        has_fine_trap,
    input  logic        has_el3,
    input  logic        el3_fine_en,
    input  logic        fine_rd_trap,
    input  logic        fine_wr_trap,
    input  logic        has_tag_cache,
    output logic        rsp_valid,
    output logic [1:0]  rsp_code,
    output logic [5:0]  rsp_class,
    output logic [63:0] rsp_rdata
);
    logic              hit;
    outcome_e          outcome;
    logic              store_we;
    logic [DATA_W-1:0] view;
    rsp_state_e        state_q, state_d;

    csel_decode u_decode (
        .req_valid (req_valid),
        .op0       (req_op0),
        .op1       (req_op1),
        .crn       (req_crn),
        .crm       (req_crm),
        .op2       (req_op2),
        .hit       (hit)
    );

    csel_gate u_gate (
        .is_write       (req_write),
        .el             (cur_el),
        .el2_enabled    (el2_enabled),
        .trap_idgrp2    (trap_idgrp2),
        .trap_idgrp4    (trap_idgrp4),
        .has_ext_idtrap (has_ext_idtrap),
        .has_fine_trap  (has_fine_trap),
        .has_el3        (has_el3),
        .el3_fine_en    (el3_fine_en),
        .fine_rd_trap   (fine_rd_trap),
        .fine_wr_trap   (fine_wr_trap),
        .outcome        (outcome)
    );

    assign store_we = hit && req_write && (outcome == OUT_DONE);

    csel_store #(.NUM_LEVELS(NUM_LEVELS)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (store_we),
        .wdata         (req_wdata),
        .has_tag_cache (has_tag_cache),
        .rd_view       (view)
    );

    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE:   state_d = hit ? S_ANSWER : S_IDLE;
            S_ANSWER: state_d = hit ? S_ANSWER : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_code  <= OUT_DONE;
            rsp_class <= '0;
            rsp_rdata <= '0;
        end else if (hit) begin
            rsp_code  <= outcome;
            rsp_class <= (outcome == OUT_TRAP) ? TRAP_CLASS : '0;
            rsp_rdata <= (!req_write && outcome == OUT_DONE) ? view : '0;
        end
    end

    assign rsp_valid = (state_q == S_ANSWER);

    AST_MATCH_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op0 == 2'b11 && req_op1 == 3'b010 && req_crn == 4'd0 &&
         req_crm == 4'd0 && req_op2 == 3'd0) |=> rsp_valid); // R2
    AST_NO_MATCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_op0 == 2'b11 && req_op1 == 3'b010 && req_crn == 4'd0 &&
          req_crm == 4'd0 && req_op2 == 3'd0) |=> !rsp_valid); // R1
    AST_EL0_UNDEFINED: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cur_el == 2'd0) |=> rsp_code == 2'd1); // R3
    AST_HIGH_EL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cur_el[1]) |=> rsp_code == 2'd0); // R4
    AST_EL1_NO_HYP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cur_el == 2'd1 && !el2_enabled) |=> rsp_code == 2'd0); // R5
    AST_GRP2_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cur_el == 2'd1 && el2_enabled && trap_idgrp2) |=>
        (rsp_code == 2'd2 && rsp_class == 6'h18)); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_rdata[63:5] == '0); // R9
endmodule

// File: tb/tb_sysreg_cachesel.sv
`timescale 1ns/1ps
module tb_sysreg_cachesel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_op0 = 2'b11;
    logic [2:0]  req_op1 = 3'b010;
    logic [3:0]  req_crn = 4'd0, req_crm = 4'd0;
    logic [2:0]  req_op2 = 3'd0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  cur_el = 2'd3;
    logic        el2_enabled = 0, trap_idgrp2 = 0, trap_idgrp4 = 0, has_ext_idtrap = 0;
    logic        has_fine_trap = 0, has_el3 = 1, el3_fine_en = 0;
    logic        fine_rd_trap = 0, fine_wr_trap = 0, has_tag_cache = 0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [5:0]  rsp_class;
    logic [63:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [1:0] C_DONE = 2'd0, C_UNDEF = 2'd1, C_TRAP = 2'd2;

    always #4 clk = ~clk;

    sysreg_cachesel dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_ctrl();
        el2_enabled = 0; trap_idgrp2 = 0; trap_idgrp4 = 0; has_ext_idtrap = 0;
        has_fine_trap = 0; has_el3 = 1; el3_fine_en = 0; fine_rd_trap = 0; fine_wr_trap = 0;
    endtask

    // one access; outputs sampled on the negedge after the capturing posedge
    task automatic access(input logic wr, input logic [1:0] el, input logic [63:0] wd,
                          output logic [1:0] code, output logic [63:0] rd);
        @(negedge clk);
        req_valid = 1; req_write = wr; cur_el = el; req_wdata = wd;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        chk("R2 rsp_valid", {63'b0, rsp_valid}, 64'd1);
        code = rsp_code;
        rd   = rsp_rdata;
    endtask

    task automatic rd_el3(input string req, input logic [63:0] exp);
        logic [1:0]  c;
        logic [63:0] d;
        access(1'b0, 2'd3, '0, c, d);
        chk(req, d, exp);
    endtask

    task automatic wr_el3(input logic [63:0] wd);
        logic [1:0]  c;
        logic [63:0] d;
        access(1'b1, 2'd3, wd, c, d);
    endtask

    task automatic t_reset();
        chk("R13 rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);
        rd_el3("R13 reset value", 64'd0);
    endtask

    task automatic t_decode();
        @(negedge clk);
        req_valid = 1; req_write = 1; req_op2 = 3'd1; req_wdata = 64'h3; cur_el = 2'd3;
        @(negedge clk);
        req_valid = 0; req_op2 = 3'd0;
        chk("R1 no response to other encoding", {63'b0, rsp_valid}, 64'd0);
        rd_el3("R1 other-encoding write ignored", 64'd0);
        @(negedge clk);
        chk("R2 single-cycle strobe", {63'b0, rsp_valid}, 64'd0);
    endtask

    task automatic t_el_levels();
        logic [1:0]  c;
        logic [63:0] d;
        access(1'b1, 2'd0, 64'h5, c, d);
        chk("R3 EL0 write undefined", {62'b0, c}, C_UNDEF);
        access(1'b0, 2'd0, '0, c, d);
        chk("R3 EL0 read undefined", {62'b0, c}, C_UNDEF);
        chk("R14 undefined read data zero", d, 64'd0);
        rd_el3("R14 EL0 write left storage", 64'd0);
        el2_enabled = 1; trap_idgrp2 = 1;
        access(1'b1, 2'd2, 64'h5, c, d);
        chk("R4 EL2 write done", {62'b0, c}, C_DONE);
        access(1'b0, 2'd3, '0, c, d);
        chk("R4 EL3 read done", {62'b0, c}, C_DONE);
        chk("R9 field layout readback", d, 64'h5);
        clear_ctrl();
        wr_el3(64'hFFFF_FFFF_FFFF_FFE2);
        rd_el3("R9 upper bits read zero", 64'h2);
        trap_idgrp2 = 1; trap_idgrp4 = 1; has_ext_idtrap = 1; has_fine_trap = 1;
        fine_rd_trap = 1; fine_wr_trap = 1; el3_fine_en = 1;
        access(1'b0, 2'd1, '0, c, d);
        chk("R5 EL1 without hypervisor done", {62'b0, c}, C_DONE);
        chk("R5 read data", d, 64'h2);
        clear_ctrl();
    endtask

    task automatic t_traps();
        logic [1:0]  c;
        logic [63:0] d;
        el2_enabled = 1; trap_idgrp2 = 1;
        access(1'b1, 2'd1, 64'h4, c, d);
        chk("R6 group-2 trap", {62'b0, c}, C_TRAP);
        chk("R6 syndrome class", {58'b0, rsp_class}, 64'h18);
        chk("R14 trapped data zero", d, 64'd0);
        rd_el3("R14 trapped write left storage", 64'h2);
        trap_idgrp2 = 0; trap_idgrp4 = 1;
        access(1'b0, 2'd1, '0, c, d);
        chk("R7 group-4 without feature done", {62'b0, c}, C_DONE);
        has_ext_idtrap = 1;
        access(1'b0, 2'd1, '0, c, d);
        chk("R7 group-4 with feature trap", {62'b0, c}, C_TRAP);
        chk("R7 syndrome class", {58'b0, rsp_class}, 64'h18);
        trap_idgrp4 = 0; has_fine_trap = 1; has_el3 = 1; el3_fine_en = 0; fine_rd_trap = 1;
        access(1'b0, 2'd1, '0, c, d);
        chk("R8 level-3 enable off done", {62'b0, c}, C_DONE);
        el3_fine_en = 1;
        access(1'b0, 2'd1, '0, c, d);
        chk("R8 read fine trap", {62'b0, c}, C_TRAP);
        access(1'b1, 2'd1, 64'h4, c, d);
        chk("R8 write ignores read bit", {62'b0, c}, C_DONE);
        fine_rd_trap = 0; fine_wr_trap = 1;
        access(1'b1, 2'd1, 64'h6, c, d);
        chk("R8 write fine trap", {62'b0, c}, C_TRAP);
        access(1'b0, 2'd1, '0, c, d);
        chk("R8 read ignores write bit", {62'b0, c}, C_DONE);
        chk("R14 trapped write kept value", d, 64'h4);
        fine_wr_trap = 0; fine_rd_trap = 1; has_el3 = 0; el3_fine_en = 0;
        access(1'b0, 2'd1, '0, c, d);
        chk("R8 no level 3 trap", {62'b0, c}, C_TRAP);
        has_fine_trap = 0;
        access(1'b0, 2'd1, '0, c, d);
        chk("R8 feature absent done", {62'b0, c}, C_DONE);
        clear_ctrl();
    endtask

    task automatic t_fields();
        has_tag_cache = 1;
        wr_el3(64'h10);
        rd_el3("R10 tag stored with feature", 64'h10);
        has_tag_cache = 0;
        rd_el3("R10 tag hidden without feature", 64'h0);
        has_tag_cache = 1;
        wr_el3(64'h11);
        rd_el3("R10 tag forced off with instr bit", 64'h1);
        has_tag_cache = 0;
        wr_el3(64'h10);
        has_tag_cache = 1;
        rd_el3("R10 tag not stored without feature", 64'h0);
        wr_el3(64'h4);
        wr_el3(64'hE);
        rd_el3("R11 reserved level kept", 64'h4);
        wr_el3(64'hF);
        rd_el3("R11 instr bit updates", 64'h5);
        wr_el3(64'h7);
        rd_el3("R12 unimplemented level masked", 64'h0);
        wr_el3(64'h16);
        rd_el3("R12 unimplemented level with tag", 64'h10);
        has_tag_cache = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_el_levels();
        t_traps();
        t_fields();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule